// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive approximation analog-to-digital converter. It resolves a binary code by searching the input range in halves. An external DAC turns the block's trial code into a voltage. An external comparator returns one bit, which is high when the analog input lies above that voltage. The analog parts and any sample-and-hold sit outside this block.

A single-cycle start request, taken only while the block is idle, loads a trial code with only the most significant bit set. On each following clock edge the block samples the comparator for the bit under test. It keeps that bit or clears it, and sets the next lower bit as the new trial. Once the least significant bit has been decided, the block flips the level of its end-of-conversion output and copies the final code into a separate result latch. That latch holds its value until the next completion.

A conversion always takes W+1 rising edges, counting the edge that accepts the start request. This holds for every input value, so downstream logic can read results at fixed intervals.

Top module: `sar_ctrl`

## Requirements
- R1: A synchronous reset drives the trial code, the result latch, the busy flag and the end-of-conversion level to zero.
- R2: A start request seen while busy is low makes the trial code exactly the MSB alone (0x80 for W=8) and raises busy, both on the next edge.
- R3: On each edge while busy, the bit under test takes the comparator value sampled at that edge (1 keeps it, 0 clears it), and the next lower bit is set as the new trial.
- R4: Bits are decided one per edge, strictly from the MSB down to the LSB, and a bit that has been decided never changes again during that conversion.
- R5: Busy falls, and the end-of-conversion output changes level, on the W-th edge after the edge that accepted start (W+1 edges in total), for every input value.
- R6: The result latch changes only on the edge where the end-of-conversion level flips, and it then holds the final code; during a conversion it keeps the previous result.
- R7: A start request that arrives while busy is high has no effect on the trial code, the timing or the result.
- R8: With an ideal DAC and a comparator fed an input of code v plus half an LSB (comparator high exactly when v >= trial code), every code v from 0 to 2^W-1 is recovered exactly.
- R9: For an input at 9.5/12 of full scale (code 202), the comparator sequence is 1,1,0,0,1,0,1,0 and the result is 11001010. For code 44, the decisions read 00101100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, taken only when idle |
| cmp_hi | input | 1 | Comparator bit: analog input above the DAC output |
| trial_code | output | W | Code driven to the external DAC |
| result | output | W | Latched code of the last finished conversion |
| busy | output | 1 | High from the accepted start until completion |
| eoc | output | 1 | End-of-conversion level; it toggles once per finished conversion |

## Verification
The trial code with only the MSB set, together with busy, is due one edge after start is accepted. Each later edge adds one decided bit to the trial code. Busy, the end-of-conversion toggle and the new result all land on edge W after the accepting edge. The bench drives inputs on falling edges, samples one time unit after each rising edge, and counts exactly the number of edges that each result needs. The comparator model follows the trial code combinationally, so each decision uses the trial code that was presented one edge earlier.

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         cmp_hi,
  output logic [W-1:0] trial_code,
  output logic [W-1:0] result,
  output logic         busy,
  output logic         eoc
);

  localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] probe;

  wire          launch  = start & ~busy;
  wire          last    = probe[0];
  wire [W-1:0]  decided = cmp_hi ? trial_code : (trial_code & ~probe);

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_code <= '0;
      probe      <= '0;
      result     <= '0;
      busy       <= 1'b0;
      eoc        <= 1'b0;
    end else if (launch) begin
      trial_code <= TOP;
      probe      <= TOP;
      busy       <= 1'b1;
    end else if (busy) begin
      trial_code <= decided | (probe >> 1);
      probe      <= probe >> 1;
      if (last) begin
        busy   <= 1'b0;
        eoc    <= ~eoc;
        result <= decided;
      end
    end
  end

endmodule

module sar_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] trial_code,
  input logic [W-1:0] result,
  input logic         busy,
  input logic         eoc
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (trial_code == '0 && result == '0 && !busy && !eoc));

  // R2
  launch_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && trial_code == {1'b1, {(W-1){1'b0}}}));

  // R5
  done_toggles_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !$stable(eoc));

  // R6
  result_on_eoc_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> !$stable(eoc));

  // R6
  eoc_only_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(eoc) |-> $fell(busy));

endmodule

bind sar_ctrl sar_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .trial_code(trial_code),
  .result(result), .busy(busy), .eoc(eoc)
);

// File: tb/sim_sar_ctrl.sv
module sim_sar_ctrl;
  localparam int W = 8;
  localparam int CLK_P = 10;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cmp_hi;
  logic [W-1:0] trial_code, result;
  logic busy, eoc;
  logic [W-1:0] vin = '0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  assign cmp_hi = (vin >= trial_code);

  sar_ctrl #(.W(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .cmp_hi(cmp_hi),
    .trial_code(trial_code), .result(result), .busy(busy), .eoc(eoc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(input int v, input bit inject, input int exp_seq, input bit seq_chk);
    logic [W-1:0] prev_res;
    logic prev_eoc;
    logic [W-1:0] seq;
    int dmask, expt;
    prev_res = result;
    prev_eoc = eoc;
    seq = '0;
    @(negedge clk);
    vin = v[W-1:0];
    start = 1'b1;
    @(posedge clk); #1;
    chk(trial_code == (1 << (W-1)), "R2 trial", int'(trial_code), 1 << (W-1));
    chk(busy == 1'b1, "R2 busy", int'(busy), 1);
    for (int step = 0; step < W; step++) begin
      @(negedge clk);
      start = inject && (step == 2);
      seq[W-1-step] = cmp_hi;
      @(posedge clk); #1;
      if (step < W-1) begin
        dmask = ((1 << W) - 1) & ~((1 << (W-1-step)) - 1);
        expt = (v & dmask) | (1 << (W-2-step));
        chk(trial_code == expt[W-1:0], inject ? "R7 R3 R4 trial" : "R3 R4 trial", int'(trial_code), expt);
        chk(busy == 1'b1, "R5 busy held", int'(busy), 1);
        chk(result == prev_res, "R6 result held", int'(result), int'(prev_res));
      end else begin
        chk(busy == 1'b0, "R5 busy drop", int'(busy), 0);
        chk(eoc != prev_eoc, "R5 eoc toggle", int'(eoc), int'(!prev_eoc));
        chk(result == v[W-1:0], inject ? "R7 R8 result" : "R8 result", int'(result), v);
      end
    end
    @(negedge clk);
    start = 1'b0;
    if (seq_chk) chk(seq == exp_seq[W-1:0], "R9 sequence", int'(seq), exp_seq);
    @(posedge clk); #1;
    chk(result == v[W-1:0] && !busy, "R6 result kept after end", int'(result), v);
  endtask

  initial begin
    start = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(trial_code == '0 && result == '0, "R1 codes", int'(trial_code | result), 0);
    chk(!busy && !eoc, "R1 flags", int'({busy, eoc}), 0);
    @(negedge clk);
    rst = 1'b0;
    start = 1'b0;
    convert(202, 1'b0, 8'b11001010, 1'b1);
    chk(result == 8'b11001010, "R9 result 9.5/12", int'(result), 202);
    convert(44, 1'b0, 8'b00101100, 1'b1);
    chk(result == 8'b00101100, "R9 result 44", int'(result), 44);
    convert(171, 1'b1, 0, 1'b0);
    for (int v = 0; v < (1 << W); v++) convert(v, (v % 5) == 3, 0, 1'b0);
    convert(255, 1'b0, 0, 1'b0);
    convert(0, 1'b0, 0, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule